// File: doc/BRIEF.md
# Card Data Word Buffer with Threshold Signalling

This block sits between a 16-bit host data port and a byte-wide card data stream and carries block data in either direction through a 32-word circular store. Each stored word packs two card bytes, the earlier byte in the low half. A byte counter tracks progress through the current block and a block counter tracks progress through the transfer. When the last byte of the last block moves, the transfer goes inactive and a done flag is raised.

Threshold logic compares the number of stored words against two programmable levels. In the card-to-host direction a level above the almost-full mark either raises a status flag or asserts a receive DMA request. In the host-to-card direction a level below the almost-empty mark either raises a status flag or asserts a transmit DMA request. A per-direction enable bit in the buffer configuration word selects status or request. Firmware or a DMA engine uses these indications to pace its reads and writes of the data port.

Top module: `sdbuf_fifo`

## Requirements
- R1: After synchronous reset all status flags, DMA requests, `xfer_done`, `xfer_active`, `card_rx_ready`, `card_tx_valid` and `host_underrun` are low. The almost-full level resets to 31 and the almost-empty level resets to 0.
- R2: A host write appends a word to the store and a host read removes the oldest word, in first-in first-out order. The read word appears on `host_rd_data` in the cycle after the read strobe.
- R3: A host write while 32 words are stored is dropped and the stored contents are unchanged.
- R4: A host read while the store is empty changes no state. `host_underrun` is high for the one cycle after that read.
- R5: Writing `blen_wr_data` (11 bits, value v) sets the block length to v+1 bytes and reloads the byte counter. Writing `bcnt_wr_data` (11 bits, value v) sets the block count to v+1 and reloads the byte counter from the block length.
- R6: In the card-to-host direction, bytes fill a word low half first and then high half. When a block has odd length, its last byte is stored alone in a word whose high half is zero.
- R7: In the host-to-card direction, each word is sent low byte first and then high byte. When a block has odd length, the high byte of its last word is not sent.
- R8: When the last byte of a block moves, the byte counter reloads and the block counter decrements. When the last byte of the last block moves, the block counter reloads, `xfer_active` falls and `xfer_done` rises. A following transfer runs without reprogramming the counters.
- R9: In the card-to-host direction, a word count above the almost-full level asserts `rx_dma_req` when the receive DMA enable (bit 15 of the configuration word) is set, and asserts `stat_afull` otherwise. At any other count both are low. The level is in bits 12:8.
- R10: In the host-to-card direction, a word count below the almost-empty level asserts `tx_dma_req` when the transmit DMA enable (bit 7) is set, and asserts `stat_aempty` otherwise. At any other count both are low. The level is in bits 4:0.
- R11: With no transfer active and the store empty, all four threshold outputs are low.
- R12: `card_rx_ready` is low when no card-to-host transfer is active, and also low at a word boundary while the count is above the almost-full level. `card_tx_valid` is low when no host-to-card transfer is active, and also low at a word boundary while the store is empty.
- R13: `xfer_start` empties the store, latches the direction from `xfer_to_host` (1 = card to host), sets the transfer active and clears `xfer_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr_en | input | 1 | Host data-port write strobe |
| host_wr_data | input | 16 | Host write word |
| host_rd_en | input | 1 | Host data-port read strobe |
| host_rd_data | output | 16 | Word read, registered |
| host_underrun | output | 1 | Read of empty store, one-cycle pulse |
| cfg_wr_en | input | 1 | Buffer configuration write strobe |
| cfg_wr_data | input | 16 | DMA enables and threshold levels |
| blen_wr_en | input | 1 | Block length write strobe |
| blen_wr_data | input | 11 | Block length minus one, in bytes |
| bcnt_wr_en | input | 1 | Block count write strobe |
| bcnt_wr_data | input | 11 | Block count minus one |
| xfer_start | input | 1 | Start a data transfer |
| xfer_to_host | input | 1 | Direction for the start: 1 card to host |
| card_rx_valid | input | 1 | Card byte offered |
| card_rx_data | input | 8 | Card byte |
| card_rx_ready | output | 1 | Block accepts a card byte |
| card_tx_valid | output | 1 | Block offers a byte to the card |
| card_tx_data | output | 8 | Byte to the card |
| card_tx_ready | input | 1 | Card takes the byte |
| stat_afull | output | 1 | Almost-full status |
| stat_aempty | output | 1 | Almost-empty status |
| rx_dma_req | output | 1 | Receive DMA request |
| tx_dma_req | output | 1 | Transmit DMA request |
| xfer_done | output | 1 | Transfer completed, sticky until next start |
| xfer_active | output | 1 | Transfer in progress |

## Verification
The assertions assume the host reads the port only while data flows card to host or no transfer runs, and writes it only while data flows host to card or no transfer runs. They also assume `xfer_start` arrives only while no transfer is active and that no two counter or configuration writes share a cycle. The bench keeps to these rules by construction: during each transfer it drives only the strobe that fits the direction, and it issues every register write in an otherwise quiet cycle between transfers, except one configuration write made mid-transfer to move the receive indication from status to request.

// File: rtl/sdbuf_pkg.sv
package sdbuf_pkg;

  localparam int LVL_W = 5;
  localparam int REG_W = 16;

  typedef struct packed {
    logic             rx_dma;
    logic [1:0]       rsv_a;
    logic [LVL_W-1:0] af_lvl;
    logic             tx_dma;
    logic [1:0]       rsv_b;
    logic [LVL_W-1:0] ae_lvl;
  } buf_cfg_t;

  localparam buf_cfg_t CFG_RESET = '{
    rx_dma: 1'b0, rsv_a: 2'b00, af_lvl: {LVL_W{1'b1}},
    tx_dma: 1'b0, rsv_b: 2'b00, ae_lvl: {LVL_W{1'b0}}
  };

  function automatic buf_cfg_t cfg_decode(input logic [REG_W-1:0] v);
    buf_cfg_t c;
    c = buf_cfg_t'(v);
    c.rsv_a = 2'b00;
    c.rsv_b = 2'b00;
    return c;
  endfunction

endpackage

// File: rtl/sdbuf_ram.sv
module sdbuf_ram #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/sdbuf_blkcnt.sv
module sdbuf_blkcnt #(
  parameter int LEN_W = 11,
  localparam int CNT_W = LEN_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             len_wr,
  input  logic [LEN_W-1:0] len_val,
  input  logic             num_wr,
  input  logic [LEN_W-1:0] num_val,
  input  logic             step,
  output logic             last_byte,
  output logic             xfer_end
);

  logic [CNT_W-1:0] blen_q, bytes_q, nblk_q, blocks_q;

  assign last_byte = (bytes_q == CNT_W'(1));
  assign xfer_end  = step && last_byte && (blocks_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      blen_q   <= '0;
      bytes_q  <= '0;
      nblk_q   <= '0;
      blocks_q <= '0;
    end else if (len_wr) begin
      blen_q  <= {1'b0, len_val} + CNT_W'(1);
      bytes_q <= {1'b0, len_val} + CNT_W'(1);
    end else if (num_wr) begin
      nblk_q   <= {1'b0, num_val} + CNT_W'(1);
      blocks_q <= {1'b0, num_val} + CNT_W'(1);
      bytes_q  <= blen_q;
    end else if (step) begin
      if (last_byte) begin
        bytes_q <= blen_q;
        if (blocks_q == CNT_W'(1)) blocks_q <= nblk_q;
        else                       blocks_q <= blocks_q - CNT_W'(1);
      end else begin
        bytes_q <= bytes_q - CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/sdbuf_levels.sv
module sdbuf_levels
  import sdbuf_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  buf_cfg_t      cfg_n,
  input  logic [CW-1:0] count_n,
  input  logic          active_n,
  input  logic          to_host_n,
  output logic          afull,
  output logic          aempty,
  output logic          rx_req,
  output logic          tx_req
);

  logic quiet, rx_hit, tx_hit;

  always_comb begin
    quiet  = !active_n && (count_n == '0);
    rx_hit = !quiet && to_host_n  && (count_n > CW'(cfg_n.af_lvl));
    tx_hit = !quiet && !to_host_n && (count_n < CW'(cfg_n.ae_lvl));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      afull  <= 1'b0;
      aempty <= 1'b0;
      rx_req <= 1'b0;
      tx_req <= 1'b0;
    end else begin
      afull  <= rx_hit && !cfg_n.rx_dma;
      rx_req <= rx_hit &&  cfg_n.rx_dma;
      aempty <= tx_hit && !cfg_n.tx_dma;
      tx_req <= tx_hit &&  cfg_n.tx_dma;
    end
  end

endmodule

// File: rtl/sdbuf_fifo.sv
module sdbuf_fifo
  import sdbuf_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int BYTE_W = 8,
  parameter int LEN_W  = 11,
  localparam int WORD_W = 2 * BYTE_W,
  localparam int AW     = $clog2(DEPTH),
  localparam int CW     = AW + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr_en,
  input  logic [WORD_W-1:0] host_wr_data,
  input  logic              host_rd_en,
  output logic [WORD_W-1:0] host_rd_data,
  output logic              host_underrun,
  input  logic              cfg_wr_en,
  input  logic [REG_W-1:0]  cfg_wr_data,
  input  logic              blen_wr_en,
  input  logic [LEN_W-1:0]  blen_wr_data,
  input  logic              bcnt_wr_en,
  input  logic [LEN_W-1:0]  bcnt_wr_data,
  input  logic              xfer_start,
  input  logic              xfer_to_host,
  input  logic              card_rx_valid,
  input  logic [BYTE_W-1:0] card_rx_data,
  output logic              card_rx_ready,
  output logic              card_tx_valid,
  output logic [BYTE_W-1:0] card_tx_data,
  input  logic              card_tx_ready,
  output logic              stat_afull,
  output logic              stat_aempty,
  output logic              rx_dma_req,
  output logic              tx_dma_req,
  output logic              xfer_done,
  output logic              xfer_active
);

  logic [AW-1:0]     start_q, start_n;
  logic [CW-1:0]     count_q, count_n;
  logic              active_q, active_n;
  logic              dir_q, dir_n;
  logic              phase_q, phase_n;
  logic [BYTE_W-1:0] hold_q;
  logic              done_q;
  buf_cfg_t          cfg_q, cfg_n;
  logic [WORD_W-1:0] head_word, wr_word;
  logic              host_push, host_pop, card_push, card_pop;
  logic              rx_take, tx_take, byte_step, last_byte, xfer_end;
  logic              push, pop;

  // storage
  sdbuf_ram #(.DEPTH(DEPTH), .WIDTH(WORD_W)) u_ram (
    .clk   (clk),
    .we    (push),
    .waddr (start_q + count_q[AW-1:0]),
    .wdata (wr_word),
    .raddr (start_q),
    .rdata (head_word)
  );

  // byte and block accounting
  sdbuf_blkcnt #(.LEN_W(LEN_W)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .len_wr    (blen_wr_en),
    .len_val   (blen_wr_data),
    .num_wr    (bcnt_wr_en),
    .num_val   (bcnt_wr_data),
    .step      (byte_step),
    .last_byte (last_byte),
    .xfer_end  (xfer_end)
  );

  // card side handshakes
  assign card_rx_ready = active_q && dir_q &&
                         (phase_q || (count_q <= CW'(cfg_q.af_lvl)));
  assign card_tx_valid = active_q && !dir_q && (phase_q || (count_q != '0));
  assign card_tx_data  = phase_q ? head_word[WORD_W-1:BYTE_W] : head_word[BYTE_W-1:0];

  assign rx_take   = card_rx_valid && card_rx_ready;
  assign tx_take   = card_tx_valid && card_tx_ready;
  assign byte_step = rx_take || tx_take;

  // a word moves when its high byte moves, or early on the last byte of a block
  assign card_push = rx_take && (phase_q || last_byte);
  assign card_pop  = tx_take && (phase_q || last_byte);
  assign host_push = host_wr_en && (count_q != CW'(DEPTH));
  assign host_pop  = host_rd_en && (count_q != '0);
  assign push      = host_push || card_push;
  assign pop       = host_pop || card_pop;

  always_comb begin
    if (host_push)    wr_word = host_wr_data;
    else if (phase_q) wr_word = {card_rx_data, hold_q};
    else              wr_word = {{BYTE_W{1'b0}}, card_rx_data};
  end

  always_comb begin
    cfg_n = cfg_wr_en ? cfg_decode(cfg_wr_data) : cfg_q;
    if (xfer_start) begin
      count_n  = '0;
      start_n  = '0;
      active_n = 1'b1;
      dir_n    = xfer_to_host;
      phase_n  = 1'b0;
    end else begin
      count_n  = count_q + CW'(push) - CW'(pop);
      start_n  = start_q + AW'(pop);
      active_n = xfer_end ? 1'b0 : active_q;
      dir_n    = dir_q;
      phase_n  = byte_step ? (!phase_q && !last_byte) : phase_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q       <= '0;
      count_q       <= '0;
      active_q      <= 1'b0;
      dir_q         <= 1'b0;
      phase_q       <= 1'b0;
      hold_q        <= '0;
      done_q        <= 1'b0;
      cfg_q         <= CFG_RESET;
      host_rd_data  <= '0;
      host_underrun <= 1'b0;
    end else begin
      start_q       <= start_n;
      count_q       <= count_n;
      active_q      <= active_n;
      dir_q         <= dir_n;
      phase_q       <= phase_n;
      cfg_q         <= cfg_n;
      host_underrun <= host_rd_en && (count_q == '0);
      if (rx_take && !phase_q) hold_q <= card_rx_data;
      if (host_rd_en)          host_rd_data <= head_word;
      if (xfer_start)          done_q <= 1'b0;
      else if (xfer_end)       done_q <= 1'b1;
    end
  end

  // threshold indications, registered from next state
  sdbuf_levels #(.DEPTH(DEPTH)) u_lvl (
    .clk       (clk),
    .rst       (rst),
    .cfg_n     (cfg_n),
    .count_n   (count_n),
    .active_n  (active_n),
    .to_host_n (dir_n),
    .afull     (stat_afull),
    .aempty    (stat_aempty),
    .rx_req    (rx_dma_req),
    .tx_req    (tx_dma_req)
  );

  assign xfer_done   = done_q;
  assign xfer_active = active_q;

endmodule

// File: rtl/sdbuf_fifo_chk.sv
module sdbuf_fifo_chk #(
  parameter int DEPTH = 32,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst,
  input logic          host_rd_en,
  input logic          xfer_start,
  input logic          host_underrun,
  input logic          card_rx_ready,
  input logic          card_tx_valid,
  input logic          stat_afull,
  input logic          stat_aempty,
  input logic          rx_dma_req,
  input logic          tx_dma_req,
  input logic          xfer_done,
  input logic          xfer_active,
  input logic [CW-1:0] count_q
);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    count_q <= CW'(DEPTH)); // R3

  AST_UNDERRUN_CAUSE: assert property (@(posedge clk) disable iff (rst)
    host_underrun |-> $past(host_rd_en)); // R4

  AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (rst)
    !(card_rx_ready && card_tx_valid)); // R12

  AST_IDLE_NO_CARD: assert property (@(posedge clk) disable iff (rst)
    !xfer_active |-> (!card_rx_ready && !card_tx_valid)); // R12

  AST_DONE_ENDS_XFER: assert property (@(posedge clk) disable iff (rst)
    $rose(xfer_done) |-> !xfer_active); // R8

  AST_START_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    $past(xfer_start) |-> (count_q == '0 && !xfer_done && xfer_active)); // R13

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!xfer_active && count_q == '0) |->
      !(stat_afull || stat_aempty || rx_dma_req || tx_dma_req)); // R11

  AST_SIDES_EXCL: assert property (@(posedge clk) disable iff (rst)
    (stat_afull || rx_dma_req) |-> !(stat_aempty || tx_dma_req)); // R9

endmodule

bind sdbuf_fifo sdbuf_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .host_rd_en    (host_rd_en),
  .xfer_start    (xfer_start),
  .host_underrun (host_underrun),
  .card_rx_ready (card_rx_ready),
  .card_tx_valid (card_tx_valid),
  .stat_afull    (stat_afull),
  .stat_aempty   (stat_aempty),
  .rx_dma_req    (rx_dma_req),
  .tx_dma_req    (tx_dma_req),
  .xfer_done     (xfer_done),
  .xfer_active   (xfer_active),
  .count_q       (count_q)
);

// File: tb/sdbuf_fifo_test.sv
`timescale 1ns/1ps
module sdbuf_fifo_test;

  localparam int DEPTH = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic        host_wr_en = 0, host_rd_en = 0;
  logic [15:0] host_wr_data = 0;
  logic [15:0] host_rd_data;
  logic        host_underrun;
  logic        cfg_wr_en = 0, blen_wr_en = 0, bcnt_wr_en = 0;
  logic [15:0] cfg_wr_data = 0;
  logic [10:0] blen_wr_data = 0, bcnt_wr_data = 0;
  logic        xfer_start = 0, xfer_to_host = 0;
  logic        card_rx_valid = 0;
  logic [7:0]  card_rx_data = 0;
  logic        card_rx_ready, card_tx_valid, card_tx_ready = 0;
  logic [7:0]  card_tx_data;
  logic        stat_afull, stat_aempty, rx_dma_req, tx_dma_req, xfer_done, xfer_active;

  sdbuf_fifo uut (.*);

  int errors = 0, checks = 0;
  bit started = 0;
  int tx_bytes = 0, rx_bytes = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference ----------------
  int m_q[$];
  bit m_active, m_dir, m_phase, m_done, m_under, m_rd_chk;
  int m_hold, m_rd_exp;
  int m_blen, m_bytes, m_nblk, m_blocks;
  bit m_rxdma, m_txdma;
  int m_af, m_ae;
  bit m_afull, m_aempty, m_rxreq, m_txreq;

  always @(posedge clk) begin
    if (rst) begin
      m_q.delete();
      m_active = 0; m_dir = 0; m_phase = 0; m_done = 0; m_under = 0; m_rd_chk = 0;
      m_hold = 0; m_blen = 0; m_bytes = 0; m_nblk = 0; m_blocks = 0;
      m_rxdma = 0; m_txdma = 0; m_af = 31; m_ae = 0;
      m_afull = 0; m_aempty = 0; m_rxreq = 0; m_txreq = 0;
    end else begin
      int n;
      bit rxr, txv, last, hit;
      n = m_q.size();
      rxr = m_active && m_dir && (m_phase || n <= m_af);
      txv = m_active && !m_dir && (m_phase || n > 0);
      m_rd_chk = 0; m_under = 0;
      if (card_tx_valid && card_tx_ready) tx_bytes++;
      if (card_rx_valid && card_rx_ready) rx_bytes++;
      if (host_rd_en) begin
        if (n > 0) begin m_rd_exp = m_q.pop_front(); m_rd_chk = 1; end
        else m_under = 1;
      end
      if (host_wr_en && n < DEPTH) m_q.push_back(int'(host_wr_data));
      if (xfer_start) begin
        m_q.delete(); m_active = 1; m_dir = xfer_to_host; m_phase = 0; m_done = 0;
      end else if ((rxr && card_rx_valid) || (txv && card_tx_ready)) begin
        last = (m_bytes == 1);
        if (rxr && card_rx_valid) begin
          if (!m_phase) begin
            m_hold = int'(card_rx_data);
            if (last) m_q.push_back(int'(card_rx_data));
          end else m_q.push_back(int'(card_rx_data) * 256 + m_hold);
        end else if (m_phase || last) void'(m_q.pop_front());
        m_phase = m_phase ? 1'b0 : !last;
        if (last) begin
          m_bytes = m_blen;
          if (m_blocks == 1) begin m_blocks = m_nblk; m_active = 0; m_done = 1; end
          else m_blocks--;
        end else m_bytes--;
      end
      if (cfg_wr_en) begin
        m_rxdma = cfg_wr_data[15]; m_af = int'(cfg_wr_data[12:8]);
        m_txdma = cfg_wr_data[7];  m_ae = int'(cfg_wr_data[4:0]);
      end
      if (blen_wr_en) begin m_blen = int'(blen_wr_data) + 1; m_bytes = m_blen; end
      if (bcnt_wr_en) begin m_nblk = int'(bcnt_wr_data) + 1; m_blocks = m_nblk; m_bytes = m_blen; end
      n = m_q.size();
      if (!m_active && n == 0) begin
        m_afull = 0; m_rxreq = 0; m_aempty = 0; m_txreq = 0;
      end else begin
        hit = m_dir && n > m_af;
        m_afull = hit && !m_rxdma; m_rxreq = hit && m_rxdma;
        hit = !m_dir && n < m_ae;
        m_aempty = hit && !m_txdma; m_txreq = hit && m_txdma;
      end
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (started && !rst) begin
      int n;
      bit rxr, txv;
      n = m_q.size();
      rxr = m_active && m_dir && (m_phase || n <= m_af);
      txv = m_active && !m_dir && (m_phase || n > 0);
      chk("R12", "card_rx_ready", int'(card_rx_ready), int'(rxr));
      chk("R12", "card_tx_valid", int'(card_tx_valid), int'(txv));
      if (txv && n > 0)
        chk("R7", "card_tx_data", int'(card_tx_data),
            m_phase ? (m_q[0] >> 8) & 255 : m_q[0] & 255);
      chk("R9", "stat_afull", int'(stat_afull), int'(m_afull));
      chk("R9", "rx_dma_req", int'(rx_dma_req), int'(m_rxreq));
      chk("R10", "stat_aempty", int'(stat_aempty), int'(m_aempty));
      chk("R10", "tx_dma_req", int'(tx_dma_req), int'(m_txreq));
      chk("R8", "xfer_done", int'(xfer_done), int'(m_done));
      chk("R8", "xfer_active", int'(xfer_active), int'(m_active));
      chk("R4", "host_underrun", int'(host_underrun), int'(m_under));
      if (m_rd_chk) chk("R2 R6", "host_rd_data", int'(host_rd_data), m_rd_exp);
    end
  end

  // ---------------- watchdog ----------------
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d cycles", cyc, 150000);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic quiet();
    host_wr_en = 0; host_rd_en = 0; cfg_wr_en = 0; blen_wr_en = 0; bcnt_wr_en = 0;
    xfer_start = 0; card_rx_valid = 0; card_tx_ready = 0;
  endtask

  task automatic idle(input int k);
    repeat (k) begin @(negedge clk); quiet(); end
  endtask

  task automatic set_cfg(input logic [15:0] v);
    @(negedge clk); quiet(); cfg_wr_en = 1; cfg_wr_data = v;
  endtask

  task automatic set_len(input int blen_m1, input int nblk_m1);
    @(negedge clk); quiet(); blen_wr_en = 1; blen_wr_data = 11'(blen_m1);
    @(negedge clk); quiet(); bcnt_wr_en = 1; bcnt_wr_data = 11'(nblk_m1);
  endtask

  task automatic begin_xfer(input bit to_host);
    @(negedge clk); quiet(); xfer_start = 1; xfer_to_host = to_host;
    @(negedge clk); quiet();
    chk("R13", "active after start", int'(xfer_active), 1);
    chk("R13", "done cleared by start", int'(xfer_done), 0);
    chk("R13", "store emptied", int'(card_tx_valid), 0);
  endtask

  task automatic run_tx(input int nwords);
    int sent = 0;
    for (int it = 0; it < 4000; it++) begin
      @(negedge clk); quiet();
      if (!m_active && m_q.size() == 0 && sent >= nwords) break;
      card_tx_ready = ($urandom % 3) != 0;
      if (sent < nwords && m_q.size() < DEPTH && ($urandom % 2) == 1) begin
        host_wr_en = 1; host_wr_data = 16'($urandom); sent++;
      end
    end
  endtask

  task automatic run_rx(input int limit, input int rd_pct);
    for (int it = 0; it < limit; it++) begin
      @(negedge clk); quiet();
      if (!m_active && m_q.size() == 0) break;
      card_rx_valid = ($urandom % 4) != 0;
      card_rx_data  = 8'($urandom);
      host_rd_en    = m_q.size() > 0 && int'($urandom % 100) < rd_pct;
    end
  endtask

  initial begin
    logic [15:0] last_word;
    quiet();
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1", "stat_afull", int'(stat_afull), 0);
    chk("R1", "stat_aempty", int'(stat_aempty), 0);
    chk("R1", "dma requests", int'(rx_dma_req) + int'(tx_dma_req), 0);
    chk("R1", "xfer_done", int'(xfer_done), 0);
    chk("R1", "xfer_active", int'(xfer_active), 0);
    chk("R1", "card handshakes", int'(card_rx_ready) + int'(card_tx_valid), 0);
    chk("R1", "af level reset 31", m_af, 31);
    started = 1;

    // R2 R3 R4: fill past capacity, drain, read once more
    last_word = 0;
    for (int i = 0; i < DEPTH + 1; i++) begin
      @(negedge clk); quiet(); host_wr_en = 1; host_wr_data = 16'(16'h1000 + i);
      if (i == DEPTH - 1) last_word = host_wr_data;
    end
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk); quiet(); host_rd_en = 1;
    end
    @(negedge clk); quiet(); host_rd_en = 1;
    chk("R3", "last stored word is the 32nd", int'(host_rd_data), int'(last_word));
    @(negedge clk); quiet();
    chk("R4", "underrun pulse", int'(host_underrun), 1);
    host_wr_en = 1; host_wr_data = 16'hBEEF;
    @(negedge clk); quiet(); host_rd_en = 1;
    @(negedge clk); quiet();
    chk("R4", "state intact after underrun", int'(host_rd_data), 16'hBEEF);
    chk("R11", "idle empty flags",
        int'(stat_afull) + int'(stat_aempty) + int'(rx_dma_req) + int'(tx_dma_req), 0);

    // R5 R7 R10: host to card, odd block of 5 bytes, 2 blocks, status mode
    set_cfg(16'h1F04);
    set_len(4, 1);
    tx_bytes = 0;
    begin_xfer(1'b0);
    run_tx(6);
    idle(2);
    chk("R5", "tx byte total", tx_bytes, 10);
    chk("R8", "done after tx", int'(xfer_done), 1);

    // R8 R10: reloaded counters, request mode
    set_cfg(16'h1F86);
    tx_bytes = 0;
    begin_xfer(1'b0);
    run_tx(6);
    idle(2);
    chk("R8", "tx byte total without reprogramming", tx_bytes, 10);

    // R6 R9: card to host, 3-byte blocks x3, low almost-full level
    set_cfg(16'h0300);
    set_len(2, 2);
    rx_bytes = 0;
    begin_xfer(1'b1);
    run_rx(40, 5);
    set_cfg(16'h8300);
    @(negedge clk); quiet();
    chk("R9", "enabling receive DMA drops status", int'(stat_afull), 0);
    run_rx(4000, 30);
    idle(2);
    chk("R5", "rx byte total", rx_bytes, 9);
    chk("R8", "done after rx", int'(xfer_done), 1);

    // R9 R12: longer blocks, status mode, slow host
    set_cfg(16'h0500);
    set_len(9, 3);
    rx_bytes = 0;
    begin_xfer(1'b1);
    run_rx(6000, 20);
    idle(2);
    chk("R5", "rx byte total long", rx_bytes, 40);
    chk("R11", "idle after rx",
        int'(stat_afull) + int'(stat_aempty) + int'(rx_dma_req) + int'(tx_dma_req), 0);

    idle(3);
    started = 0;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule